// File: doc/BRIEF.md
# Dual-List Page Frame Allocator

This block hands out and takes back physical page frames from a fixed pool. Each frame has a two-bit state and a link field. These fields thread two singly linked lists through one array. The first list holds frames that are free but hold stale contents. The second holds frames that are free and already cleared. A single request port carries three kinds of request: allocate for the kernel, allocate for a user, and release a frame. The kernel draws on stale frames first. A user draws on cleared frames first. When no cleared frame exists, a user request takes a stale frame and has it cleared before the frame is returned.

Clearing is done outside the block through a level request, a frame index and a done pulse. Whenever no request is waiting, the block uses this same port to clear stale frames in the background and move them onto the cleared list. A new request cancels that work between frames. The frame that was being cleared stays on the stale list.

Top module: `page_pool_alloc`

## Requirements
- R1: After reset, the block links frames 0 to NPAGES-1 in ascending order into the stale list, one per cycle, with the cleared list empty. `req_ready` stays low throughout this phase, so the first kernel allocations return 0, 1, 2 and so on.
- R2: A kernel allocation pops the head of the stale list. If that list is empty, it pops the head of the cleared list.
- R3: A user allocation pops the head of the cleared list. If that list is empty, it pops the stale head, drives `zero_req` high with `zero_page` set to that frame, and responds only in the cycle after `zero_done`.
- R4: A release of a frame not in the stale state pushes it onto the head of the stale list, so the next kernel allocation returns it. The response echoes the frame with `rsp_err` = 0.
- R5: Releasing a frame that is already in the stale state responds with `rsp_err` = 2 and the echoed frame, and leaves both lists unchanged. A frame sitting on the cleared list is not treated as stale and is accepted.
- R6: An allocation that finds both lists empty responds with `rsp_err` = 1 and `rsp_page` all ones.
- R7: Popping a frame whose state does not match the list it sits on responds with `rsp_err` = 3 and `rsp_page` all ones, and leaves that list unchanged.
- R8: When the block is idle with no request and the stale head is in the stale state, it raises `zero_req` with `zero_page` equal to the stale head. On `zero_done`, that frame moves to the head of the cleared list.
- R9: A request arriving during background clearing drops `zero_req` in the next cycle unless `zero_done` arrives in the same cycle. The frame stays at the head of the stale list. `req_ready` is high only when the block is idle.
- R10: `rsp_valid` is a one-cycle pulse in the cycle after the request is accepted. The only exception is on-demand clearing, which follows R3. Error codes are 0 for success, 1 for out of memory, 2 for double release and 3 for corruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_free | input | 1 | 1 = release `req_page`, 0 = allocate |
| req_user | input | 1 | Allocation is for a user (1) or the kernel (0) |
| req_page | input | IW | Frame to release |
| rsp_valid | output | 1 | Response pulse |
| rsp_page | output | IW | Frame returned or echoed, all ones on failure |
| rsp_err | output | 2 | 0 ok, 1 out of memory, 2 double release, 3 corruption |
| zero_req | output | 1 | Clearing of `zero_page` requested (level) |
| zero_page | output | IW | Frame to clear |
| zero_done | input | 1 | Clearing of `zero_page` finished |

## Verification
The hardest situation to reach from the ports is the corruption report. A correct pool only reaches it when a frame that sits on the cleared list is released. The double-release rule lets that release through, and the frame's link and state are then overwritten. To get there, the bench lets the background engine clear the whole pool, releases the head of the cleared list, and then issues a user allocation that pops that frame. A bench-side clearing model answers `zero_req` only while the bench enables it. This keeps background progress deterministic, so the bench can also hold a frame in mid-clear and then preempt it.

// File: rtl/page_pool_alloc.sv
module page_pool_alloc #(
  parameter int NPAGES = 16,
  parameter int AW = $clog2(NPAGES),
  parameter int IW = $clog2(NPAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_free,
  input  logic          req_user,
  input  logic [IW-1:0] req_page,
  output logic          rsp_valid,
  output logic [IW-1:0] rsp_page,
  output logic [1:0]    rsp_err,
  output logic          zero_req,
  output logic [IW-1:0] zero_page,
  input  logic          zero_done
);
  localparam logic [IW-1:0] NIL = {IW{1'b1}};
  localparam logic [IW-1:0] LAST = IW'(NPAGES - 1);
  localparam logic [1:0] PG_FREE = 2'd0, PG_USED = 2'd1, PG_ZERO = 2'd2;
  localparam logic [1:0] E_OK = 2'd0, E_OOM = 2'd1, E_DBL = 2'd2, E_BAD = 2'd3;

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_BGZ, S_ZWAIT} st_t;
  st_t st;

  logic [1:0]    pst [NPAGES];
  logic [IW-1:0] nxt [NPAGES];
  logic [IW-1:0] fhd, zhd, wpg;

  logic [AW-1:0] fa, za, ra, wa;
  assign fa = fhd[AW-1:0];
  assign za = zhd[AW-1:0];
  assign ra = req_page[AW-1:0];
  assign wa = wpg[AW-1:0];

  logic f_empty, z_empty, f_ok, z_ok, r_free, use_f, use_z, take;
  assign f_empty = (fhd == NIL);
  assign z_empty = (zhd == NIL);
  assign f_ok    = (pst[fa] == PG_FREE);
  assign z_ok    = (pst[za] == PG_ZERO);
  assign r_free  = (pst[ra] == PG_FREE);
  assign use_z   = req_user ? !z_empty : (f_empty && !z_empty);
  assign use_f   = req_user ? (z_empty && !f_empty) : !f_empty;
  assign take    = (st == S_IDLE) && req_valid;

  assign req_ready = (st == S_IDLE);
  assign zero_req  = (st == S_BGZ) || (st == S_ZWAIT);
  assign zero_page = wpg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_INIT;
      wpg <= '0;
      fhd <= '0;
      zhd <= NIL;
      rsp_valid <= 1'b0;
      rsp_page <= NIL;
      rsp_err <= E_OK;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_INIT: begin
          wpg <= wpg + 1'b1;
          if (wpg == LAST) st <= S_IDLE;
        end
        S_IDLE: begin
          if (req_valid) begin
            rsp_valid <= 1'b1;
            rsp_page <= NIL;
            rsp_err <= E_OK;
            if (req_free) begin
              rsp_page <= req_page;
              if (r_free) rsp_err <= E_DBL;
              else fhd <= req_page;
            end else if (use_f) begin
              if (!f_ok) rsp_err <= E_BAD;
              else begin
                fhd <= nxt[fa];
                if (req_user) begin
                  rsp_valid <= 1'b0;
                  wpg <= fhd;
                  st <= S_ZWAIT;
                end else rsp_page <= fhd;
              end
            end else if (use_z) begin
              if (!z_ok) rsp_err <= E_BAD;
              else begin
                zhd <= nxt[za];
                rsp_page <= zhd;
              end
            end else rsp_err <= E_OOM;
          end else if (!f_empty && f_ok) begin
            wpg <= fhd;
            st <= S_BGZ;
          end
        end
        S_BGZ: begin
          if (zero_done) begin
            fhd <= nxt[wa];
            zhd <= wpg;
            st <= S_IDLE;
          end else if (req_valid) st <= S_IDLE;
        end
        default: begin
          if (zero_done) begin
            rsp_valid <= 1'b1;
            rsp_page <= wpg;
            rsp_err <= E_OK;
            st <= S_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_INIT) begin
      pst[wa] <= PG_FREE;
      nxt[wa] <= (wpg == LAST) ? NIL : wpg + 1'b1;
    end else if (take && req_free) begin
      if (!r_free) begin
        pst[ra] <= PG_FREE;
        nxt[ra] <= fhd;
      end
    end else if (take && use_f) begin
      if (f_ok) pst[fa] <= PG_USED;
    end else if (take && use_z) begin
      if (z_ok) pst[za] <= PG_USED;
    end else if (st == S_BGZ && zero_done) begin
      pst[wa] <= PG_ZERO;
      nxt[wa] <= zhd;
    end
  end

  assert_free_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_free) |=> (rsp_valid && rsp_page == $past(req_page)));

  assert_nil_on_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_err == E_OOM || rsp_err == E_BAD)) |-> (rsp_page == NIL));

  assert_ondemand_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ZWAIT && zero_done) |=> (rsp_valid && rsp_err == E_OK && !zero_req));

  assert_zpage_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_req && !zero_done) |=> (!zero_req || $stable(zero_page)));

  assert_bg_yield_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BGZ && req_valid && !zero_done) |=> (req_ready && !zero_req));

  assert_no_ready_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INIT) |-> (!req_ready && !rsp_valid));
endmodule

// File: tb/page_pool_alloc_bench.sv
`timescale 1ns/1ps
module page_pool_alloc_bench;
  localparam int NP = 16;
  localparam int IW = 5;
  localparam int ZLAT = 3;
  localparam logic [IW-1:0] NIL = {IW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_free = 1'b0, req_user = 1'b0;
  logic [IW-1:0] req_page = '0;
  logic rsp_valid;
  logic [IW-1:0] rsp_page;
  logic [1:0] rsp_err;
  logic zero_req, zero_done;
  logic [IW-1:0] zero_page;
  logic zen = 1'b0;
  int zcnt;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  page_pool_alloc #(.NPAGES(NP)) u_page_pool_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_free(req_free), .req_user(req_user), .req_page(req_page),
    .rsp_valid(rsp_valid), .rsp_page(rsp_page), .rsp_err(rsp_err),
    .zero_req(zero_req), .zero_page(zero_page), .zero_done(zero_done));

  always @(posedge clk) begin
    if (zen && zero_req && !zero_done) begin
      zcnt <= zcnt + 1;
      zero_done <= (zcnt == ZLAT - 1);
    end else begin
      zcnt <= 0;
      zero_done <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; zen = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // op: 0 kernel alloc, 1 user alloc, 2 release
  task automatic do_req(input int op, input logic [IW-1:0] pg,
                        output logic [IW-1:0] rpg, output logic [1:0] rerr, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_free = (op == 2); req_user = (op == 1); req_page = pg;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    zen = 1'b1;
    lat = 0;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    zen = 1'b0;
    rpg = rsp_page;
    rerr = rsp_err;
  endtask

  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 5'd0, 5'd0, 2'd0},   // R1 first kernel frame is 0
    {2'd0, 5'd0, 5'd1, 2'd0},   // R1 ascending order
    {2'd1, 5'd0, 5'd2, 2'd0},   // R3 user, cleared list empty -> on demand
    {2'd2, 5'd1, 5'd1, 2'd0},   // R4 release 1
    {2'd2, 5'd1, 5'd1, 2'd2},   // R5 release 1 again
    {2'd0, 5'd0, 5'd1, 2'd0},   // R4 LIFO head
    {2'd0, 5'd0, 5'd3, 2'd0},   // R5 no duplicate of 1 on list
    {2'd2, 5'd0, 5'd0, 2'd0},   // R4 release 0
    {2'd1, 5'd0, 5'd0, 2'd0}    // R3 on demand again
  };

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [IW-1:0] p;
    logic [1:0] e;
    int lat;

    repeat (2) @(negedge clk);
    chk(!req_ready, "R1 ready low in reset", req_ready, 0);
    chk(!rsp_valid, "R10 no response in reset", rsp_valid, 0);
    chk(!zero_req, "R8 no clearing in reset", zero_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R1 ready low during init", req_ready, 0);

    for (int i = 0; i < NV; i++) begin
      do_req(int'(VEC[i][13:12]), VEC[i][11:7], p, e, lat);
      chk(p == VEC[i][6:2], $sformatf("R2/R3/R4/R5 vector %0d page", i), p, VEC[i][6:2]);
      chk(e == VEC[i][1:0], $sformatf("R5/R10 vector %0d err", i), e, VEC[i][1:0]);
      if (VEC[i][13:12] != 2'd1)
        chk(lat == 0, $sformatf("R10 vector %0d latency", i), lat, 0);
      else
        chk(lat > 0, $sformatf("R3 vector %0d waited for clearing", i), lat, 1);
    end

    // R8 R9: background clearing holds stale head, then yields
    do_reset();
    repeat (NP + 6) @(negedge clk);
    chk(zero_req, "R8 background clearing active", zero_req, 1);
    chk(zero_page == 0, "R8 background frame is stale head", zero_page, 0);
    do_req(0, 0, p, e, lat);
    chk(p == 0 && e == 0, "R9 preempted frame still at stale head", p, 0);
    chk(lat == 0, "R10 kernel latency", lat, 0);
    repeat (3) @(negedge clk);
    chk(zero_req && zero_page == 1, "R8 next stale head offered", zero_page, 1);

    // R8 R2 R3: clear whole pool, then fall back
    do_reset();
    zen = 1'b1;
    repeat (300) @(negedge clk);
    zen = 1'b0;
    chk(!zero_req, "R8 pool fully cleared", zero_req, 0);
    do_req(0, 0, p, e, lat);
    chk(p == 15 && e == 0, "R2 kernel falls back to cleared list", p, 15);
    do_req(1, 0, p, e, lat);
    chk(p == 14 && e == 0, "R3 user takes cleared head", p, 14);
    chk(lat == 0, "R3 no on-demand clearing when cleared frame exists", lat, 0);
    for (int k = 13; k >= 0; k--) begin
      do_req(0, 0, p, e, lat);
      chk(p == IW'(k), "R2 drain cleared list", p, k);
    end
    do_req(0, 0, p, e, lat);
    chk(e == 2'd1 && p == NIL, "R6 kernel out of memory", e, 1);
    do_req(1, 0, p, e, lat);
    chk(e == 2'd1 && p == NIL, "R6 user out of memory", e, 1);

    // R7: release a frame sitting on the cleared list, then pop it
    do_reset();
    zen = 1'b1;
    repeat (300) @(negedge clk);
    zen = 1'b0;
    do_req(2, 15, p, e, lat);
    chk(e == 0 && p == 15, "R5 cleared frame release accepted", e, 0);
    do_req(1, 0, p, e, lat);
    chk(e == 2'd3 && p == NIL, "R7 corruption on cleared pop", e, 3);
    do_req(0, 0, p, e, lat);
    chk(e == 0 && p == 15, "R4 released frame on stale head", p, 15);
    do_req(1, 0, p, e, lat);
    chk(e == 2'd3 && p == NIL, "R7 cleared head left unchanged", e, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule